// File: doc/BRIEF.md
# Tone-Bus Receive Message FIFO

This block collects reply bytes from a satellite-dish control tone bus and holds them for a host processor. A bit-level demodulator, outside this block, presents each decoded byte with its received parity bit. The block tests the parity, stores the byte and its parity status in a small FIFO, and keeps a packed status byte. That byte holds the FIFO occupancy, a received flag, a completion flag, an overflow flag and a no-reply timeout flag. An interrupt line follows the status flags when the host enables it.

Reception is driven by a four-state window machine. ST_IDLE waits for the block's own transmission to end (`tx_done`). ST_HOLDOFF counts a fixed number of milliseconds. ST_LISTEN waits for a start bit and gives up after a configurable number of milliseconds. ST_RECEIVE accepts bytes until the demodulator signals the end of the message. The transitions are these. A `tx_done` moves any state to ST_HOLDOFF. The holdoff expiry moves ST_HOLDOFF to ST_LISTEN. A start bit moves ST_LISTEN to ST_RECEIVE, and the listen expiry moves ST_LISTEN to ST_IDLE. An end-of-message indication moves ST_RECEIVE to ST_IDLE. The millisecond time base comes from a system-clock divider parameter, so a bench can use a small divisor.

The host reads each stored byte as two reads of the FIFO port. The first read gives the data and the second gives the parity information. Longer messages must be drained while they arrive.

Top module: `tonebus_rx_fifo`

## Requirements
- R1: After `tx_done` is sampled, `rx_start` and `rx_valid` are ignored for exactly HOLDOFF_MS*CLK_DIV cycles. Listening begins on the edge that ends that span.
- R2: If no start bit arrives within TIMEOUT_MS*CLK_DIV cycles after listening begins, status bit 3 sets on the edge that ends that span. Status bit 1 is never set together with bit 3.
- R3: Status bit 0 sets on the edge where the first byte of a message is accepted in ST_RECEIVE.
- R4: An `rx_msg_end` in ST_RECEIVE sets status bit 1 and returns the machine to ST_IDLE. A waiting complete message shows status[1:0] = 2'b11.
- R5: Status bits [7:4] equal the number of bytes held in the FIFO (0 to DEPTH).
- R6: On a non-empty FIFO, the first `rd_fifo` of a pair leaves `fifo_rdata` showing the head data byte. After that read, `fifo_rdata` shows {6'b0, parity_error, parity_bit}. The entry is removed, and the count drops, only on the second read.
- R7: Parity is odd over the 8 data bits. The stored parity_error is 1 exactly when the received parity bit differs from the odd-parity value of the data.
- R8: A byte that arrives while DEPTH entries are held, with no pop in the same cycle, is dropped and sets sticky status bit 2. An `rd_status` clears bit 2.
- R9: While `pin_dir_in` is 0, `rx_start`, `rx_valid` and `rx_msg_end` have no effect.
- R10: `irq` is 1 exactly when `irq_en` is 1 and any of status bits 0, 1 or 3 is set.
- R11: After reset, `status`, `fifo_rdata` and `irq` are 0.
- R12: `rd_fifo` on an empty FIFO has no effect, and `fifo_rdata` reads 0.
- R13: `tx_done` clears status bits 0, 1 and 3 and restarts the holdoff. Stored bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done | input | 1 | Pulse: own transmission has finished |
| pin_dir_in | input | 1 | Shared pin direction, 1 selects receive |
| irq_en | input | 1 | Receive interrupt enable |
| rx_start | input | 1 | Demodulator saw a start bit |
| rx_valid | input | 1 | Demodulator byte strobe |
| rx_data | input | 8 | Decoded data byte |
| rx_parity | input | 1 | Received parity bit |
| rx_msg_end | input | 1 | Demodulator end-of-message indication |
| rd_fifo | input | 1 | Read strobe of the FIFO register |
| rd_status | input | 1 | Read strobe of the status register |
| fifo_rdata | output | 8 | FIFO register read value |
| status | output | 8 | {count[3:0], timeout, overflow, complete, received} |
| irq | output | 1 | Receive interrupt |

## Verification
The bench aims a start bit and a byte at the last holdoff cycle, where a timer off by one would store a byte that should have been dropped. It samples the timeout flag one cycle before and on the expiry edge, which catches a listen window that closes early or late. It stores a byte with a bad parity bit, which a design with even parity or a swapped flag pair would report wrongly, and it checks the count between the two reads of a pair to catch a pop on the first read. It pushes ten bytes into the eight-entry FIFO to catch a design that overwrites entries or fails to hold or clear the overflow flag. It also checks that a start bit seen with the pin set to output does not open reception.

// File: rtl/tbrx_pkg.sv
package tbrx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLDOFF,
        ST_LISTEN,
        ST_RECEIVE
    } win_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       par;
    } rx_entry_t;
endpackage

// File: rtl/tbrx_ms_timer.sv
module tbrx_ms_timer #(
    parameter int CLK_DIV = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic ms_tick
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [DW-1:0] div_cnt;

    assign ms_tick = (div_cnt == DW'(CLK_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (restart || ms_tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tbrx_window_fsm.sv
module tbrx_window_fsm
    import tbrx_pkg::*;
#(
    parameter int HOLDOFF_MS = 5,
    parameter int TIMEOUT_MS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_done,
    input  logic ms_tick,
    input  logic start_ok,
    input  logic end_ok,
    input  logic byte_ok,
    output logic accept,
    output logic timer_restart,
    output logic flag_rcvd,
    output logic flag_cpl,
    output logic flag_tmo
);
    localparam int MAXMS = (HOLDOFF_MS > TIMEOUT_MS) ? HOLDOFF_MS : TIMEOUT_MS;
    localparam int MW    = $clog2(MAXMS + 1);

    win_state_t state, state_nx;
    logic [MW-1:0] ms_cnt;
    logic holdoff_done, listen_expired;

    assign holdoff_done   = ms_tick && (ms_cnt == MW'(HOLDOFF_MS - 1));
    assign listen_expired = ms_tick && (ms_cnt == MW'(TIMEOUT_MS - 1));

    always_comb begin
        state_nx = state;
        if (tx_done) begin
            state_nx = ST_HOLDOFF;
        end else begin
            unique case (state)
                ST_IDLE:    state_nx = ST_IDLE;
                ST_HOLDOFF: if (holdoff_done) state_nx = ST_LISTEN;
                ST_LISTEN: begin
                    if (start_ok)            state_nx = ST_RECEIVE;
                    else if (listen_expired) state_nx = ST_IDLE;
                end
                ST_RECEIVE: if (end_ok) state_nx = ST_IDLE;
            endcase
        end
    end

    assign timer_restart = (state_nx != state) || tx_done;
    assign accept        = (state == ST_RECEIVE);

    // state register and millisecond counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ms_cnt <= '0;
        end else begin
            state <= state_nx;
            if (timer_restart) ms_cnt <= '0;
            else if (ms_tick)  ms_cnt <= ms_cnt + 1'b1;
        end
    end

    // status flag outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_rcvd <= 1'b0;
            flag_cpl  <= 1'b0;
            flag_tmo  <= 1'b0;
        end else if (tx_done) begin
            flag_rcvd <= 1'b0;
            flag_cpl  <= 1'b0;
            flag_tmo  <= 1'b0;
        end else begin
            if (accept && byte_ok) flag_rcvd <= 1'b1;
            if (accept && end_ok)  flag_cpl  <= 1'b1;
            if (state == ST_LISTEN && !start_ok && listen_expired) flag_tmo <= 1'b1;
        end
    end
endmodule

// File: rtl/tbrx_fifo.sv
module tbrx_fifo
    import tbrx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  rx_entry_t                    push_entry,
    input  logic                         rd_strobe,
    input  logic                         ovf_clr,
    output logic [7:0]                   rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t     mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          phase;
    logic          nonempty, full, pop, do_push;

    assign nonempty = (count != '0);
    assign full     = (count == CW'(DEPTH));
    assign pop      = rd_strobe && nonempty && phase;
    assign do_push  = push && (!full || pop);

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (do_push && (wr_ptr == PW'(g))) begin
                mem[g] <= push_entry;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            phase  <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)     rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(pop);
            if (rd_strobe && nonempty) phase <= ~phase;
            if (push && full && !pop) ovf <= 1'b1;
            else if (ovf_clr)         ovf <= 1'b0;
        end
    end

    always_comb begin
        if (!nonempty)  rdata = 8'h00;
        else if (phase) rdata = {6'b0, mem[rd_ptr].perr, mem[rd_ptr].par};
        else            rdata = mem[rd_ptr].data;
    end
endmodule

// File: rtl/tonebus_rx_fifo.sv
module tonebus_rx_fifo
    import tbrx_pkg::*;
#(
    parameter int CLK_DIV    = 125000,
    parameter int HOLDOFF_MS = 5,
    parameter int TIMEOUT_MS = 20,
    parameter int DEPTH      = 8   // at most 15: count shares a 4-bit status field
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_done,
    input  logic       pin_dir_in,
    input  logic       irq_en,
    input  logic       rx_start,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_parity,
    input  logic       rx_msg_end,
    input  logic       rd_fifo,
    input  logic       rd_status,
    output logic [7:0] fifo_rdata,
    output logic [7:0] status,
    output logic       irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          ms_tick, timer_restart, accept;
    logic          start_ok, end_ok, byte_ok;
    logic          f_rcvd, f_cpl, f_tmo, f_ovf;
    logic [CW-1:0] count;
    rx_entry_t     entry;

    assign start_ok = rx_start   && pin_dir_in;
    assign end_ok   = rx_msg_end && pin_dir_in;
    assign byte_ok  = rx_valid   && pin_dir_in;

    assign entry.data = rx_data;
    assign entry.par  = rx_parity;
    assign entry.perr = rx_parity ^ ~(^rx_data);

    tbrx_ms_timer #(.CLK_DIV(CLK_DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timer_restart),
        .ms_tick (ms_tick)
    );

    tbrx_window_fsm #(.HOLDOFF_MS(HOLDOFF_MS), .TIMEOUT_MS(TIMEOUT_MS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_done       (tx_done),
        .ms_tick       (ms_tick),
        .start_ok      (start_ok),
        .end_ok        (end_ok),
        .byte_ok       (byte_ok),
        .accept        (accept),
        .timer_restart (timer_restart),
        .flag_rcvd     (f_rcvd),
        .flag_cpl      (f_cpl),
        .flag_tmo      (f_tmo)
    );

    tbrx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (byte_ok && accept),
        .push_entry (entry),
        .rd_strobe  (rd_fifo),
        .ovf_clr    (rd_status),
        .rdata      (fifo_rdata),
        .count      (count),
        .ovf        (f_ovf)
    );

    assign status = {4'(count), f_tmo, f_ovf, f_cpl, f_rcvd};
    assign irq    = irq_en && (f_rcvd || f_cpl || f_tmo);
endmodule

// File: rtl/tonebus_rx_fifo_chk.sv
module tonebus_rx_fifo_chk #(
    parameter int DEPTH = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_done,
    input logic       pin_dir_in,
    input logic       irq_en,
    input logic       rx_valid,
    input logic       rd_fifo,
    input logic       rd_status,
    input logic [7:0] fifo_rdata,
    input logic [7:0] status,
    input logic       irq
);
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:4] <= 4'(DEPTH));                                             // R5
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);                                                       // R10
    AST_TMO_NO_CPL: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] |-> !status[1]);                                             // R2
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7:4] == 4'd0) |-> (fifo_rdata == 8'h00));                      // R12
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !rx_valid) |=> !status[2]);                              // R8
    AST_DIR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_dir_in && rx_valid && !rd_fifo) |=> (status[7:4] == $past(status[7:4]))); // R9
    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> (status[1:0] == 2'b00 && !status[3]));                     // R13
endmodule

bind tonebus_rx_fifo tonebus_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_done    (tx_done),
    .pin_dir_in (pin_dir_in),
    .irq_en     (irq_en),
    .rx_valid   (rx_valid),
    .rd_fifo    (rd_fifo),
    .rd_status  (rd_status),
    .fifo_rdata (fifo_rdata),
    .status     (status),
    .irq        (irq)
);

// File: tb/tonebus_rx_fifo_test.sv
module tonebus_rx_fifo_test;
    localparam int DIV = 10;
    localparam int HMS = 5;
    localparam int TMS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_done = 1'b0, pin_dir_in = 1'b1, irq_en = 1'b0;
    logic       rx_start = 1'b0, rx_valid = 1'b0, rx_parity = 1'b0, rx_msg_end = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rd_fifo = 1'b0, rd_status = 1'b0;
    logic [7:0] fifo_rdata, status;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    logic [9:0] exp_q[$];

    always #4 clk = ~clk;

    tonebus_rx_fifo #(.CLK_DIV(DIV), .HOLDOFF_MS(HMS), .TIMEOUT_MS(TMS), .DEPTH(8)) uut (
        .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .pin_dir_in(pin_dir_in),
        .irq_en(irq_en), .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_parity(rx_parity), .rx_msg_end(rx_msg_end), .rd_fifo(rd_fifo),
        .rd_status(rd_status), .fifo_rdata(fifo_rdata), .status(status), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tx();
        tx_done = 1'b1; tick(1); tx_done = 1'b0;
    endtask

    task automatic open_msg();
        pulse_tx(); tick(HMS * DIV);
        rx_start = 1'b1; tick(1); rx_start = 1'b0;
    endtask

    // driver: presents a byte and records the expected FIFO entry
    task automatic send_byte(input logic [7:0] d, input logic bad, input logic store);
        logic p;
        p = ~(^d) ^ bad;
        rx_data = d; rx_parity = p; rx_valid = 1'b1;
        tick(1);
        rx_valid = 1'b0;
        if (store) exp_q.push_back({d, bad, p});
    endtask

    // monitor: pops the next expected entry and compares a two-read pair
    task automatic read_pair(input string req);
        logic [9:0] e;
        logic [3:0] c0;
        e  = exp_q.pop_front();
        c0 = status[7:4];
        chk({req, " data"}, fifo_rdata, e[9:2]);
        rd_fifo = 1'b1; tick(1); rd_fifo = 1'b0;
        chk({req, " flags"}, fifo_rdata, {6'b0, e[1:0]});
        chk("R6 count held mid-pair", status[7:4], c0);
        rd_fifo = 1'b1; tick(1); rd_fifo = 1'b0;
        chk("R6 count after pair", status[7:4], c0 - 4'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R11 status", status, 8'h00);
        chk("R11 rdata", fifo_rdata, 8'h00);
        chk("R11 irq", irq, 1'b0);

        rd_fifo = 1'b1; tick(1); rd_fifo = 1'b0;
        chk("R12 empty rdata", fifo_rdata, 8'h00);
        chk("R12 empty count", status[7:4], 4'd0);

        // R1 boundary: start and byte on the last holdoff edge are ignored
        pulse_tx();
        tick(HMS * DIV - 1);
        rx_start = 1'b1; rx_valid = 1'b1; rx_data = 8'h77; rx_parity = 1'b0;
        tick(1);
        rx_start = 1'b0; rx_valid = 1'b0;
        chk("R1 holdoff byte dropped", status[7:4], 4'd0);
        // R9: start with pin set to output is ignored
        pin_dir_in = 1'b0; rx_start = 1'b1; tick(1); rx_start = 1'b0; pin_dir_in = 1'b1;
        send_byte(8'h55, 1'b0, 1'b0);
        chk("R9 no reception", status[7:4], 4'd0);
        chk("R9 no rcvd flag", status[0], 1'b0);
        // R2: timeout exactly TMS*DIV after listen opened
        tick(TMS * DIV - 3);
        chk("R2 before expiry", status[3], 1'b0);
        tick(1);
        chk("R2 timeout flag", status[3], 1'b1);
        chk("R2 no complete", status[1], 1'b0);
        chk("R10 irq masked", irq, 1'b0);
        irq_en = 1'b1; #1;
        chk("R10 irq on timeout", irq, 1'b1);

        // normal message
        pulse_tx();
        chk("R13 timeout cleared", status[3], 1'b0);
        tick(HMS * DIV);
        rx_start = 1'b1; tick(1); rx_start = 1'b0;
        send_byte(8'hA5, 1'b0, 1'b1);
        chk("R3 received flag", status[0], 1'b1);
        send_byte(8'h3C, 1'b1, 1'b1);
        send_byte(8'h00, 1'b0, 1'b1);
        chk("R5 count three", status[7:4], 4'd3);
        rx_msg_end = 1'b1; tick(1); rx_msg_end = 1'b0;
        chk("R4 complete", status[1:0], 2'b11);
        chk("R10 irq", irq, 1'b1);
        read_pair("R6 R7 byte0");
        read_pair("R7 bad parity");
        read_pair("R6 byte2");

        // overflow
        pulse_tx();
        chk("R13 flags cleared", status[1:0], 2'b00);
        tick(HMS * DIV);
        rx_start = 1'b1; tick(1); rx_start = 1'b0;
        for (int i = 0; i < 10; i++) send_byte(8'h10 + 8'(i), i[0], i < 8);
        chk("R8 count full", status[7:4], 4'd8);
        chk("R8 overflow set", status[2], 1'b1);
        rd_status = 1'b1; tick(1); rd_status = 1'b0;
        chk("R8 overflow cleared", status[2], 1'b0);
        for (int i = 0; i < 8; i++) read_pair("R6 R8 drain");
        chk("R5 drained", status[7:4], 4'd0);
        irq_en = 1'b0; #1;
        chk("R10 irq disabled", irq, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule